// File: doc/BRIEF.md
# Store Buffer with Byte-Granular Load Forwarding

This block sits between the execute stage of one core and its data cache. Stores that have already retired are written into a small circular queue in program order. The queue drains one entry per cycle into the cache, oldest first. The oldest entry waits whenever the cache side reports that it does not hold the target line with write permission. Because these entries are already architectural, a pipeline flush leaves them in place, and they still commit later.

Loads look up the queue in the same cycle they are presented. The search runs per byte lane and picks the youngest buffered store to the same word that writes at least one requested byte. If that store supplies every requested byte, the load completes with forwarded data. If it supplies only some of them, the load stalls until that store has left the queue. If no buffered store touches the requested bytes, the load reads the cache at once, ahead of any older stores still waiting. A fence request is held off until the queue is empty.

Top module: `sb_store_buffer`

## Requirements
- R1: A store is accepted on a rising clock edge when `st_valid` and `st_ready` are both high. `st_ready` is low exactly when the queue holds DEPTH entries (8 by default), and a store offered while it is low is dropped.
- R2: `cm_valid` is high whenever the queue is not empty. `cm_addr`, `cm_data` and `cm_mask` then show the oldest entry. One entry leaves per cycle when `cm_own` is high, and entries leave in the order they were accepted.
- R3: While `cm_own` is low, the oldest entry stays in place and the commit outputs hold their values.
- R4: A load with `ld_valid` high selects the youngest buffered entry that has an equal address and at least one byte set in both masks. If that entry's mask covers every byte of `ld_mask`, then in the same cycle `ld_done` is 1, `cache_rd_req` is 0 and `ld_data` carries that entry's bytes in the requested lanes.
- R5: If the selected entry covers only some of the requested bytes, then `ld_stall` is 1 and both `ld_done` and `cache_rd_req` are 0. This holds until that entry commits, even when an older entry covers the whole load.
- R6: If no entry is selected, then in the same cycle `cache_rd_req` is 1, `cache_rd_addr` equals `ld_addr`, `ld_done` is 1 and `ld_data` is `cache_rd_data` restricted to the requested lanes. This happens whatever other stores are still buffered. With `ld_valid` low, `ld_done`, `ld_stall` and `cache_rd_req` are all 0.
- R7: `fence_stall` equals `fence_req` while the queue holds at least one entry, and is 0 when the queue is empty.
- R8: While `flush` is high, `ld_done`, `ld_stall` and `cache_rd_req` are all 0. Buffered entries are kept and commit afterwards in order, and store acceptance is unaffected.
- R9: The lookup sees the queue as it stood at the start of the cycle. A store accepted in the same cycle is not visible to that load. An entry committing in that cycle is still visible to it.
- R10: Addresses are word addresses. Mask bit k covers data bits [8k+7:8k], and requested lanes outside `ld_mask` read as zero in `ld_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Retired store offered |
| st_ready | output | 1 | Queue has room |
| st_addr | input | 32 | Store word address |
| st_data | input | 32 | Store data |
| st_mask | input | 4 | Store byte enables |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | 32 | Load word address |
| ld_mask | input | 4 | Load byte lanes requested |
| ld_done | output | 1 | Load completes this cycle |
| ld_stall | output | 1 | Load held by partial overlap |
| ld_data | output | 32 | Load result |
| cache_rd_req | output | 1 | Cache read for an unmatched load |
| cache_rd_addr | output | 32 | Cache read address |
| cache_rd_data | input | 32 | Cache read data, same cycle |
| cm_valid | output | 1 | Oldest entry ready to commit |
| cm_addr | output | 32 | Commit address |
| cm_data | output | 32 | Commit data |
| cm_mask | output | 4 | Commit byte enables |
| cm_own | input | 1 | Line held with write permission; commit happens |
| fence_req | input | 1 | Fence waiting to issue |
| fence_stall | output | 1 | Fence must wait |
| flush | input | 1 | Pipeline flush |

## Verification
The bench writes two stores to one word, a full-width one followed by a narrow one. It then issues loads that overlap only the older store, loads that overlap both, and loads that overlap both but need more than the narrow store provides. A design that searched oldest-first, or that merged bytes from several entries, would return the older data instead of stalling. A design that ignored byte lanes would stall or forward on the wrong loads. Further cases cover a store and a load to one word in the same cycle, and a load to the word whose entry is committing in that cycle. A lookup with the wrong snapshot timing would forward too early in the first case, or read stale cache data in the second. Flushes land while entries are still held back by missing ownership: a design that dropped entries on flush would lose commits that the reference queue still expects.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BYTES  = DATA_W / 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [BYTES-1:0]  mask_t;

    typedef struct packed {
        addr_t addr;
        data_t data;
        mask_t mask;
    } sb_entry_t;

    // Widen a byte-enable vector to a bit-enable vector.
    function automatic data_t lanes_to_bits(mask_t m);
        data_t r;
        for (int b = 0; b < BYTES; b++) begin
            r[b*8 +: 8] = {8{m[b]}};
        end
        return r;
    endfunction
endpackage

// File: rtl/sb_queue.sv
module sb_queue
    import sb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  sb_entry_t push_ent,
    input  logic      pop,
    output logic      full,
    output logic      empty,
    output sb_entry_t head_ent,
    output sb_entry_t ord_ent [DEPTH],
    output logic [DEPTH-1:0] ord_vld
);
    // DEPTH must be a power of two so the pointers wrap naturally.
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    sb_entry_t         mem [DEPTH];
    logic [PTR_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) tail_q <= tail_q + PTR_W'(1);
            if (pop)  head_q <= head_q + PTR_W'(1);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[tail_q] <= push_ent;
    end

    assign full     = (cnt_q == CNT_W'(DEPTH));
    assign empty    = (cnt_q == '0);
    assign head_ent = mem[head_q];

    // Present the contents in age order: index 0 is the oldest entry.
    for (genvar i = 0; i < DEPTH; i++) begin : g_age
        logic [PTR_W-1:0] slot;
        assign slot       = head_q + PTR_W'(i);
        assign ord_ent[i] = mem[slot];
        assign ord_vld[i] = (CNT_W'(i) < cnt_q);
    end
endmodule

// File: rtl/sb_match.sv
module sb_match
    import sb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  sb_entry_t        ord_ent [DEPTH],
    input  logic [DEPTH-1:0] ord_vld,
    input  addr_t            ld_addr,
    input  mask_t            ld_mask,
    output logic             hit,
    output logic             covered,
    output data_t            fwd_data
);
    logic [DEPTH-1:0] lane_hit;

    // One comparator per entry: same word and at least one shared byte.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign lane_hit[i] = ord_vld[i] && (ord_ent[i].addr == ld_addr)
                             && ((ord_ent[i].mask & ld_mask) != '0);
    end

    sb_entry_t sel;

    // Later (younger) indices override earlier ones: youngest match wins.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (lane_hit[i]) begin
                hit = 1'b1;
                sel = ord_ent[i];
            end
        end
    end

    assign covered  = hit && ((ld_mask & ~sel.mask) == '0);
    assign fwd_data = sel.data & lanes_to_bits(ld_mask);
endmodule

// File: rtl/sb_store_buffer.sv
module sb_store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BYTES-1:0]  st_mask,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [BYTES-1:0]  ld_mask,
    output logic              ld_done,
    output logic              ld_stall,
    output logic [DATA_W-1:0] ld_data,
    output logic              cache_rd_req,
    output logic [ADDR_W-1:0] cache_rd_addr,
    input  logic [DATA_W-1:0] cache_rd_data,
    output logic              cm_valid,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [DATA_W-1:0] cm_data,
    output logic [BYTES-1:0]  cm_mask,
    input  logic              cm_own,
    input  logic              fence_req,
    output logic              fence_stall,
    input  logic              flush
);
    logic             q_full, q_empty, push, pop;
    sb_entry_t        new_ent, head_ent;
    sb_entry_t        ord_ent [DEPTH];
    logic [DEPTH-1:0] ord_vld;
    logic             hit, covered, ld_live;
    data_t            fwd_data;

    assign new_ent = '{addr: st_addr, data: st_data, mask: st_mask};
    assign push    = st_valid && !q_full;
    assign pop     = !q_empty && cm_own;

    sb_queue #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (new_ent),
        .pop      (pop),
        .full     (q_full),
        .empty    (q_empty),
        .head_ent (head_ent),
        .ord_ent  (ord_ent),
        .ord_vld  (ord_vld)
    );

    sb_match #(.DEPTH(DEPTH)) u_match (
        .ord_ent  (ord_ent),
        .ord_vld  (ord_vld),
        .ld_addr  (ld_addr),
        .ld_mask  (ld_mask),
        .hit      (hit),
        .covered  (covered),
        .fwd_data (fwd_data)
    );

    assign st_ready = !q_full;

    assign cm_valid = !q_empty;
    assign cm_addr  = head_ent.addr;
    assign cm_data  = head_ent.data;
    assign cm_mask  = head_ent.mask;

    assign fence_stall = fence_req && !q_empty;

    // A flush cancels the lookup in flight; buffered entries are untouched.
    assign ld_live       = ld_valid && !flush;
    assign ld_stall      = ld_live && hit && !covered;
    assign ld_done       = ld_live && (!hit || covered);
    assign cache_rd_req  = ld_live && !hit;
    assign cache_rd_addr = ld_addr;
    assign ld_data       = hit ? fwd_data
                               : (cache_rd_data & lanes_to_bits(ld_mask));
endmodule

// File: rtl/sb_store_buffer_chk.sv
module sb_store_buffer_chk
    import sb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              st_valid,
    input logic              st_ready,
    input logic              cm_valid,
    input logic              cm_own,
    input logic [ADDR_W-1:0] cm_addr,
    input logic [DATA_W-1:0] cm_data,
    input logic [BYTES-1:0]  cm_mask,
    input logic              fence_req,
    input logic              fence_stall,
    input logic              ld_done,
    input logic              ld_stall,
    input logic              cache_rd_req,
    input logic              flush
);
    int occ;

    always_ff @(posedge clk) begin
        if (rst) occ <= 0;
        else     occ <= occ + int'(st_valid && st_ready) - int'(cm_valid && cm_own);
    end

    AST_READY_FULL: assert property (@(posedge clk) disable iff (rst)
        st_ready == (occ != DEPTH)); // R1

    AST_VALID_OCC: assert property (@(posedge clk) disable iff (rst)
        cm_valid == (occ != 0)); // R2

    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        cm_valid && !cm_own |=> cm_valid && $stable(cm_addr)
                                && $stable(cm_data) && $stable(cm_mask)); // R3

    AST_STALL_EXCL: assert property (@(posedge clk) disable iff (rst)
        ld_stall |-> !ld_done && !cache_rd_req); // R5

    AST_MISS_DONE: assert property (@(posedge clk) disable iff (rst)
        cache_rd_req |-> ld_done); // R6

    AST_FENCE_WAIT: assert property (@(posedge clk) disable iff (rst)
        fence_stall == (fence_req && occ != 0)); // R7

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
        flush |-> !ld_done && !ld_stall && !cache_rd_req); // R8
endmodule

bind sb_store_buffer sb_store_buffer_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sb_store_buffer_bench.sv
module sb_store_buffer_bench;
    import sb_pkg::*;
    localparam int DEPTH = 8;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    always #10 clk = ~clk;

    logic  st_valid = 0, ld_valid = 0, cm_own = 0, fence_req = 0, flush = 0;
    addr_t st_addr = '0, ld_addr = '0;
    data_t st_data = '0;
    mask_t st_mask = '0, ld_mask = '0;
    logic  st_ready, ld_done, ld_stall, cache_rd_req, cm_valid, fence_stall;
    addr_t cache_rd_addr, cm_addr;
    data_t ld_data, cache_rd_data, cm_data;
    mask_t cm_mask;

    // Cache stand-in: data is a fixed function of the address.
    assign cache_rd_data = {cache_rd_addr[15:0] ^ 16'hA5C3, cache_rd_addr[15:0]};

    sb_store_buffer #(.DEPTH(DEPTH)) u_sb_store_buffer (.*);

    typedef struct { addr_t a; data_t d; mask_t m; } ref_ent_t;
    ref_ent_t q[$];
    int    checks = 0, fails = 0;
    string ptag = "";

    function automatic data_t bitmask(mask_t m);
        data_t r;
        for (int b = 0; b < BYTES; b++) r[b*8 +: 8] = {8{m[b]}};
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s[%s] %s act=%0h exp=%0h", req, ptag, what, act, exp);
        end
    endtask

    task automatic cyc(input logic sv, input addr_t sa, input data_t sd, input mask_t sm,
                       input logic lv, input addr_t la, input mask_t lm,
                       input logic own, input logic fen, input logic fl);
        bit hit, cov;
        int idx;
        logic [2:0] flags;
        data_t cexp;
        @(negedge clk);
        st_valid = sv; st_addr = sa; st_data = sd; st_mask = sm;
        ld_valid = lv; ld_addr = la; ld_mask = lm;
        cm_own = own; fence_req = fen; flush = fl;
        #2;
        chk(st_ready == (q.size() < DEPTH), "R1", "st_ready", st_ready, q.size() < DEPTH);
        chk(cm_valid == (q.size() > 0), "R2", "cm_valid", cm_valid, q.size() > 0);
        if (q.size() > 0) begin
            chk(cm_addr == q[0].a && cm_data == q[0].d && cm_mask == q[0].m,
                own ? "R2" : "R3", "commit head", {cm_addr, cm_data}, {q[0].a, q[0].d});
        end
        chk(fence_stall == (fen && q.size() > 0), "R7", "fence_stall", fence_stall,
            fen && q.size() > 0);
        hit = 0; idx = 0;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (!hit && q[i].a == la && (q[i].m & lm) != 0) begin
                hit = 1; idx = i;
            end
        end
        cov = hit && ((lm & ~q[idx].m) == 0);
        flags = {ld_done, ld_stall, cache_rd_req};
        if (!lv || fl) begin
            chk(flags == 3'b000, fl ? "R8" : "R6", "idle load flags", flags, 3'b000);
        end else if (cov) begin
            chk(flags == 3'b100, "R4", "fwd flags", flags, 3'b100);
            chk(ld_data == (q[idx].d & bitmask(lm)), "R4", "fwd data R10 lanes",
                ld_data, q[idx].d & bitmask(lm));
        end else if (hit) begin
            chk(flags == 3'b010, "R5", "partial flags", flags, 3'b010);
        end else begin
            cexp = {la[15:0] ^ 16'hA5C3, la[15:0]} & bitmask(lm);
            chk(flags == 3'b101, "R6", "miss flags", flags, 3'b101);
            chk(cache_rd_addr == la && ld_data == cexp, "R6", "miss data",
                {cache_rd_addr, ld_data}, {la, cexp});
        end
        @(posedge clk);
        begin
            bit acc;
            acc = sv && q.size() < DEPTH;
            if (own && q.size() > 0) void'(q.pop_front());
            if (acc) q.push_back('{sa, sd, sm});
        end
    endtask

    task automatic idle(input logic own);
        cyc(0, '0, '0, '0, 0, '0, '0, own, 0, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        ptag = "R1 reset";
        cyc(0, '0, '0, '0, 1, 32'h10, 4'hF, 0, 1, 0);

        ptag = "R1 fill";
        for (int i = 0; i < 9; i++)
            cyc(1, 32'h100 + i, 32'h10203040 + i * 32'h01010101, 4'hF,
                1, 32'h100, 4'hF, 0, 0, 0);
        ptag = "R3 hold";
        repeat (3) idle(0);
        ptag = "R2 drain";
        repeat (10) idle(1);

        ptag = "R7 fence";
        for (int i = 0; i < 3; i++) cyc(1, 32'h180 + i, 32'hC0DE0000 + i, 4'hF, 0, '0, '0, 0, 0, 0);
        repeat (2) cyc(0, '0, '0, '0, 0, '0, '0, 0, 1, 0);
        repeat (5) cyc(0, '0, '0, '0, 0, '0, '0, 1, 1, 0);

        ptag = "R4 youngest";
        cyc(1, 32'h200, 32'hAAAAAAAA, 4'hF, 0, '0, '0, 0, 0, 0);
        cyc(1, 32'h200, 32'h55551234, 4'hF, 1, 32'h200, 4'hF, 0, 0, 0);
        cyc(0, '0, '0, '0, 1, 32'h200, 4'hF, 0, 0, 0);
        ptag = "R10 lane";
        cyc(0, '0, '0, '0, 1, 32'h200, 4'b0100, 0, 0, 0);
        ptag = "R5 partial";
        cyc(1, 32'h300, 32'h11223344, 4'hF, 0, '0, '0, 0, 0, 0);
        cyc(1, 32'h300, 32'h000000EE, 4'b0001, 0, '0, '0, 0, 0, 0);
        cyc(0, '0, '0, '0, 1, 32'h300, 4'b0001, 0, 0, 0);
        cyc(0, '0, '0, '0, 1, 32'h300, 4'b0011, 0, 0, 0);
        cyc(0, '0, '0, '0, 1, 32'h300, 4'b0010, 0, 0, 0);
        ptag = "R6 miss";
        cyc(0, '0, '0, '0, 1, 32'h999, 4'hF, 0, 0, 0);
        ptag = "R5 release";
        repeat (6) cyc(0, '0, '0, '0, 1, 32'h300, 4'b0011, 1, 0, 0);

        ptag = "R9 same cycle";
        cyc(1, 32'h400, 32'hFEEDBEEF, 4'hF, 1, 32'h400, 4'hF, 0, 0, 0);
        cyc(0, '0, '0, '0, 1, 32'h400, 4'hF, 1, 0, 0);
        cyc(0, '0, '0, '0, 1, 32'h400, 4'hF, 1, 0, 0);

        ptag = "R8 flush";
        for (int i = 0; i < 3; i++) cyc(1, 32'h600 + i, 32'hF1F10000 + i, 4'hF, 0, '0, '0, 0, 0, 0);
        cyc(1, 32'h603, 32'hF1F10003, 4'hF, 1, 32'h600, 4'hF, 0, 0, 1);
        cyc(0, '0, '0, '0, 1, 32'h777, 4'hF, 0, 0, 1);
        repeat (6) cyc(0, '0, '0, '0, 1, 32'h601, 4'hF, 1, 0, 0);

        ptag = "rand";
        for (int n = 0; n < 3000; n++) begin
            cyc(($urandom % 2) == 0, 32'h500 + ($urandom % 4), $urandom, mask_t'($urandom % 16),
                ($urandom % 5) < 3, 32'h500 + ($urandom % 4), mask_t'(($urandom % 15) + 1),
                ($urandom % 5) < 3, ($urandom % 10) == 0, ($urandom % 10) == 0);
        end
        ptag = "R2 final";
        repeat (10) idle(1);
        finish_run();
    end
endmodule